// File: doc/BRIEF.md
# PCI Configuration Header Register Model

This block holds the type-0 configuration header of a simple I/O-mapped serial function that exposes either one or two ports. A configuration agent reaches it through a dword-indexed port: a 6-bit dword index, 32-bit write data and four byte-lane enables. A write lands on the next rising clock edge. Read data is combinational from the index.

Reset loads a fixed identity into the header: device/vendor and subsystem words, command, status, revision and class code. Each port owns one I/O base address register that decodes an 8-byte window. Enumeration software sizes a BAR by writing all ones to it. The BAR then returns its size mask, and its I/O type bits are left alone. A strap input selects single-port or dual-port operation. In single-port mode the second BAR is held at zero. The decoded, window-aligned base of each BAR goes out on its own output for downstream address decode.

The interrupt line byte is the only other writable field. Every other field reads as a constant, and that includes the fixed interrupt pin.

Top module: `pci_cfg_hdr`

## Requirements
- R1: After reset, dword 0 reads 0x32534348, dword 1 reads 0x02000001 (status 0x0200 in the upper half, command 0x0001 in the lower half), dword 2 reads 0x07000210 (class 0x07, subclass 0x00, interface 0x02, revision 0x10) and dword 11 reads 0x32534348.
- R2: After reset, BAR0 (dword 4) reads 0x00000001. BAR1 (dword 5) reads 0x00000001 when the strap dual_port is 1, and 0x00000000 when it is 0.
- R3: A write of 0xFFFFFFFF with all four byte enables set to a present BAR stores the size mask 0xFFFFFFF8 in bits [31:2] and keeps the previous bits [1:0], so a BAR that held 0x1 then reads 0xFFFFFFF9.
- R4: Any other write to a present BAR updates each byte lane whose enable is set (enable bit n covers data bits 8n+7..8n). Lanes whose enable is clear keep their value, and bits [1:0] always keep their previous value.
- R5: When dual_port is 0, every write to BAR1 leaves it reading zero. Dwords 6, 7 and 8 (BAR2 to BAR4) read zero after any write.
- R6: Writes to dword 1 (command and status) change nothing, and it keeps reading 0x02000001.
- R7: In dword 15, byte lane 0 is the interrupt line: it resets to 0x00 and is written when enable bit 0 is set. Lane 1 (the interrupt pin) always reads 0x01, and lanes 2 and 3 read zero, whatever is written.
- R8: Dword 13 (capability pointer) reads zero. Dwords outside those named in R1 to R7 read zero, and writes to them change no readable value.
- R9: bar0_base and bar1_base equal the matching BAR value with bits [2:0] cleared.
- R10: cfg_rdata follows cfg_addr in the same cycle. A write asserted during one cycle is visible from the following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dual_port | input | 1 | Strap: 1 selects two ports, 0 selects one port (held static) |
| cfg_wr | input | 1 | Write strobe for the addressed dword |
| cfg_addr | input | 6 | Dword index into the 256-byte header |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| bar0_base | output | 32 | Window-aligned I/O base of port 0 |
| bar1_base | output | 32 | Window-aligned I/O base of port 1 |

## Verification
The bench goes after the BAR probe path in several ways. It sends an all-ones write with one lane disabled, which must be treated as an ordinary merged write and not as a probe. It sends full probes, which must keep the low type bits; a design that copied the written value would read back 0xFFFFFFFF. It writes patterns with bit 0 or bit 1 cleared to check that the I/O indicator cannot be cleared. In single-port mode it writes BAR1 and the dead BAR2 to BAR4 slots, where any stored data is an error. It also writes the command word, the pin byte and unused dwords, and checks that their read values stay unchanged. The strap is tested both ways, each after its own reset.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
   typedef logic [5:0] dw_idx_t;

   localparam dw_idx_t DW_IDENT  = 6'd0;
   localparam dw_idx_t DW_CMDSTS = 6'd1;
   localparam dw_idx_t DW_CLASS  = 6'd2;
   localparam dw_idx_t DW_BAR0   = 6'd4;
   localparam dw_idx_t DW_BAR1   = 6'd5;
   localparam dw_idx_t DW_SUBSYS = 6'd11;
   localparam dw_idx_t DW_CAPPTR = 6'd13;
   localparam dw_idx_t DW_INTR   = 6'd15;

   typedef struct packed {
      logic        wr;
      logic [3:0]  be;
      logic [31:0] data;
   } cfg_wreq_t;
endpackage

// File: rtl/pcfg_io_bar.sv
module pcfg_io_bar #(
   parameter int WIN_BYTES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        present,
   input  logic        wr_en,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic [31:0] bar_q,
   output logic [31:0] base
);
   localparam int          LOW_BITS  = $clog2(WIN_BYTES);
   localparam logic [31:0] SIZE_MASK = ~(32'(WIN_BYTES) - 32'd1);

   generate
      if (WIN_BYTES < 4 || (WIN_BYTES & (WIN_BYTES - 1)) != 0) begin : g_bad_win
         $error("pcfg_io_bar: WIN_BYTES must be a power of two of at least 4");
      end
   endgenerate

   logic [31:0] merged;
   logic [31:0] bar_d;
   logic        probe;

   always_comb begin
      for (int ln = 0; ln < 4; ln++) begin
         merged[ln*8 +: 8] = be[ln] ? wdata[ln*8 +: 8] : bar_q[ln*8 +: 8];
      end
      probe = (&be) && (wdata == 32'hFFFF_FFFF);
      if (!present)
         bar_d = 32'h0;
      else if (probe)
         bar_d = {SIZE_MASK[31:2], bar_q[1:0]};
      else
         bar_d = {merged[31:2], bar_q[1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bar_q <= present ? 32'h0000_0001 : 32'h0;
      else if (wr_en)
         bar_q <= bar_d;
   end

   assign base = {bar_q[31:LOW_BITS], {LOW_BITS{1'b0}}};

   p_type_bits_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && present) |=> (bar_q[1:0] == $past(bar_q[1:0])))
      else $error("BAR type bits changed on write");

   p_probe_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && present && (&be) && (wdata == 32'hFFFF_FFFF))
      |=> (bar_q[31:2] == SIZE_MASK[31:2]))
      else $error("BAR probe did not store size mask");

   p_absent_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !present) |=> (bar_q == 32'h0))
      else $error("absent BAR held data");

   p_base_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && present && (&be) && (wdata != 32'hFFFF_FFFF))
      |=> (base[31:LOW_BITS] == $past(wdata[31:LOW_BITS])))
      else $error("BAR base does not follow written address");
endmodule

// File: rtl/pcfg_byte_reg.sv
module pcfg_byte_reg #(
   parameter int          WIDTH = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST_VAL;
      else if (wr_en)
         q <= d;
   end
endmodule

// File: rtl/pcfg_rd_mux.sv
module pcfg_rd_mux
   import pcfg_pkg::*;
#(
   parameter logic [31:0] IDENT_WORD  = 32'h3253_4348,
   parameter logic [31:0] SUBSYS_WORD = 32'h3253_4348,
   parameter logic [15:0] CMD_VAL     = 16'h0001,
   parameter logic [15:0] STS_VAL     = 16'h0200,
   parameter logic [23:0] CLASS_CODE  = 24'h07_00_02,
   parameter logic [7:0]  REV_ID      = 8'h10,
   parameter logic [7:0]  IRQ_PIN     = 8'h01
) (
   input  dw_idx_t     addr,
   input  logic [31:0] bar0,
   input  logic [31:0] bar1,
   input  logic [7:0]  irq_line,
   output logic [31:0] rdata
);
   always_comb begin
      unique case (addr)
         DW_IDENT:  rdata = IDENT_WORD;
         DW_CMDSTS: rdata = {STS_VAL, CMD_VAL};
         DW_CLASS:  rdata = {CLASS_CODE, REV_ID};
         DW_BAR0:   rdata = bar0;
         DW_BAR1:   rdata = bar1;
         DW_SUBSYS: rdata = SUBSYS_WORD;
         DW_INTR:   rdata = {16'h0, IRQ_PIN, irq_line};
         default:   rdata = 32'h0;
      endcase
   end
endmodule

// File: rtl/pci_cfg_hdr.sv
module pci_cfg_hdr
   import pcfg_pkg::*;
#(
   parameter int          NUM_IO_BARS = 2,
   parameter int          IO_WIN      = 8,
   parameter logic [31:0] IDENT_WORD  = 32'h3253_4348,
   parameter logic [31:0] SUBSYS_WORD = 32'h3253_4348
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        dual_port,
   input  logic        cfg_wr,
   input  logic [5:0]  cfg_addr,
   input  logic [3:0]  cfg_be,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   output logic [31:0] bar0_base,
   output logic [31:0] bar1_base
);
   generate
      if (NUM_IO_BARS != 2) begin : g_bad_bars
         $error("pci_cfg_hdr: the header carries exactly two I/O BARs");
      end
   endgenerate

   cfg_wreq_t   req;
   logic [31:0] bar_val  [NUM_IO_BARS];
   logic [31:0] bar_base [NUM_IO_BARS];
   logic [7:0]  irq_line;
   logic        irq_we;

   assign req = '{wr: cfg_wr, be: cfg_be, data: cfg_wdata};

   for (genvar gi = 0; gi < NUM_IO_BARS; gi++) begin : g_bar
      logic hit;
      logic present;
      assign hit     = req.wr && (cfg_addr == DW_BAR0 + dw_idx_t'(gi));
      assign present = (gi == 0) || dual_port;
      pcfg_io_bar #(.WIN_BYTES(IO_WIN)) u_bar (
         .clk     (clk),
         .rst_n   (rst_n),
         .present (present),
         .wr_en   (hit),
         .be      (req.be),
         .wdata   (req.data),
         .bar_q   (bar_val[gi]),
         .base    (bar_base[gi])
      );
   end

   assign bar0_base = bar_base[0];
   assign bar1_base = bar_base[1];

   assign irq_we = req.wr && (cfg_addr == DW_INTR) && req.be[0];

   pcfg_byte_reg #(.WIDTH(8), .RST_VAL(8'h00)) u_irq_line (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (irq_we),
      .d     (req.data[7:0]),
      .q     (irq_line)
   );

   pcfg_rd_mux #(
      .IDENT_WORD  (IDENT_WORD),
      .SUBSYS_WORD (SUBSYS_WORD)
   ) u_rd (
      .addr     (cfg_addr),
      .bar0     (bar_val[0]),
      .bar1     (bar_val[1]),
      .irq_line (irq_line),
      .rdata    (cfg_rdata)
   );

   p_irq_line_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && cfg_addr == DW_INTR && cfg_be[0]) |=> $stable(irq_line))
      else $error("interrupt line changed without a write");

   p_irq_line_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == DW_INTR && cfg_be[0]) |=> (irq_line == $past(cfg_wdata[7:0])))
      else $error("interrupt line not loaded");

   p_bars_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && (cfg_addr == DW_BAR0 || cfg_addr == DW_BAR1))
      |=> ($stable(bar0_base) && $stable(bar1_base)))
      else $error("BAR changed without a BAR write");
endmodule

// File: tb/tb_pci_cfg_hdr.sv
module tb_pci_cfg_hdr;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dual_port = 1'b1;
   logic        cfg_wr = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata, bar0_base, bar1_base;

   int n_tests = 0;
   int n_fail  = 0;

   logic [31:0] m_bar [2];
   logic [7:0]  m_irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   pci_cfg_hdr dut (
      .clk(clk), .rst_n(rst_n), .dual_port(dual_port), .cfg_wr(cfg_wr),
      .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .bar0_base(bar0_base), .bar1_base(bar1_base)
   );

   function automatic logic [31:0] bar_next(logic [31:0] old, logic [31:0] wd,
                                            logic [3:0] be, logic present);
      logic [31:0] m;
      if (!present) return 32'h0;
      if (be == 4'hF && wd == 32'hFFFF_FFFF) return 32'hFFFF_FFF8 | {30'h0, old[1:0]};
      for (int k = 0; k < 4; k++) m[k*8 +: 8] = be[k] ? wd[k*8 +: 8] : old[k*8 +: 8];
      return {m[31:2], old[1:0]};
   endfunction

   function automatic logic [31:0] exp_read(logic [5:0] a);
      case (a)
         6'd0, 6'd11: return 32'h3253_4348;
         6'd1:  return 32'h0200_0001;
         6'd2:  return 32'h0700_0210;
         6'd4:  return m_bar[0];
         6'd5:  return m_bar[1];
         6'd15: return {16'h0, 8'h01, m_irq};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(logic [5:0] a, logic probe);
      case (a)
         6'd0, 6'd2, 6'd11: return "R1";
         6'd1: return "R6";
         6'd4: return probe ? "R3" : "R4";
         6'd5: return !dual_port ? "R5" : (probe ? "R3" : "R4");
         6'd6, 6'd7, 6'd8: return "R5";
         6'd15: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
      end
   endtask

   task automatic rd_chk(logic [5:0] a, string tag);
      @(negedge clk);
      cfg_addr = a;
      #1;
      chk(tag, cfg_rdata, exp_read(a));
   endtask

   task automatic chk_bases();
      chk("R9", bar0_base, m_bar[0] & 32'hFFFF_FFF8);
      chk("R9", bar1_base, m_bar[1] & 32'hFFFF_FFF8);
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d, logic [3:0] be);
      logic probe;
      probe = (be == 4'hF) && (d == 32'hFFFF_FFFF);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
      #1;
      chk("R10", cfg_rdata, exp_read(a));
      @(negedge clk);
      cfg_wr = 1'b0;
      if (a == 6'd4) m_bar[0] = bar_next(m_bar[0], d, be, 1'b1);
      if (a == 6'd5) m_bar[1] = bar_next(m_bar[1], d, be, dual_port);
      if (a == 6'd15 && be[0]) m_irq = d[7:0];
      #1;
      chk(tag_of(a, probe), cfg_rdata, exp_read(a));
      chk_bases();
   endtask

   task automatic do_reset(logic dual);
      @(negedge clk);
      dual_port = dual;
      rst_n = 1'b0;
      cfg_wr = 1'b0;
      m_bar[0] = 32'h1;
      m_bar[1] = dual ? 32'h1 : 32'h0;
      m_irq = 8'h0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic sweep();
      rd_chk(6'd0, "R1"); rd_chk(6'd1, "R1"); rd_chk(6'd2, "R1");
      rd_chk(6'd11, "R1"); rd_chk(6'd4, "R2"); rd_chk(6'd5, "R2");
      rd_chk(6'd13, "R8"); rd_chk(6'd15, "R7"); rd_chk(6'd3, "R8");
      rd_chk(6'd63, "R8");
      chk_bases();
   endtask

   function automatic logic [5:0] pick_addr();
      case ($urandom() % 12)
         0: return 6'd0;  1: return 6'd1;  2: return 6'd2;  3: return 6'd4;
         4: return 6'd5;  5: return 6'd6;  6: return 6'd7;  7: return 6'd8;
         8: return 6'd13; 9: return 6'd15; 10: return 6'd4;
         default: return 6'($urandom());
      endcase
   endfunction

   task automatic random_phase(int n);
      for (int i = 0; i < n; i++) begin
         logic [31:0] d;
         logic [3:0]  be;
         d  = ($urandom() % 5 == 0) ? 32'hFFFF_FFFF : $urandom();
         be = ($urandom() % 2 == 0) ? 4'hF : 4'($urandom());
         wr(pick_addr(), d, be);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      // dual-port phase
      do_reset(1'b1);
      sweep();
      wr(6'd4, 32'hFFFF_FFFF, 4'hF);           // R3 probe -> FFFFFFF9
      chk("R3", bar0_base, 32'hFFFF_FFF8);
      wr(6'd4, 32'h0000_1236, 4'hF);           // R4 low bits kept -> 00001235
      chk("R9", bar0_base, 32'h0000_1230);
      wr(6'd4, 32'hFFFF_FFFF, 4'h7);           // not a probe, merged
      wr(6'd4, 32'hAAAA_55AA, 4'b0010);        // R4 one lane
      wr(6'd5, 32'hFFFF_FFFF, 4'hF);           // R3 on BAR1
      wr(6'd5, 32'h0000_C000, 4'hF);           // R4 bit 0 cleared in data
      wr(6'd1, 32'h0000_0000, 4'hF);           // R6
      wr(6'd15, 32'hFFFF_FF0B, 4'hF);          // R7 pin fixed, line 0x0B
      wr(6'd15, 32'h0000_0077, 4'hE);          // R7 line kept
      wr(6'd6, 32'h1234_5678, 4'hF);           // R5
      wr(6'd13, 32'h0000_0040, 4'hF);          // R8
      wr(6'd40, 32'hDEAD_BEEF, 4'hF);          // R8
      random_phase(300);
      sweep();
      // single-port phase
      do_reset(1'b0);
      sweep();
      wr(6'd5, 32'h0000_2001, 4'hF);           // R5
      wr(6'd5, 32'hFFFF_FFFF, 4'hF);           // R5 probe ignored
      wr(6'd8, 32'hFFFF_FFFF, 4'hF);           // R5
      wr(6'd4, 32'h0000_3000, 4'hF);
      random_phase(300);
      sweep();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule